// File: doc/BRIEF.md
# Framed Host Register and Command Port

This block sits between a byte-wide host link and the rest of a reader core. The host opens a transaction with an open pulse and then sends 8-bit words on a valid/ready stream. The first word of each step is a head word. A head word is either a command, which raises a one-cycle strobe, or an address, which opens a data phase. A data phase is one word long in single mode and runs until a burst-end pulse in continuous mode. In the data phase each word is written to the selected register or pushed into the FIFO. For a read, each word instead fetches one byte, which comes back on a separate valid/ready result stream.

Single, continuous and command steps can follow one another inside one open/end bracket. A single-end pulse closes a command or single step and returns the port to idle. A burst-end pulse leaves continuous mode and goes back to head position, so more steps can follow. The register file sits outside the block and is reached through a plain write/read port with a same-cycle read return. The FIFO sits outside as well and is reached through a push stream and a pop stream.

Back-pressure rules: `host_ready` is low in any cycle that carries a framing pulse. It is also low in a data phase that cannot finish that cycle. A FIFO write waits for `fifo_push_ready`. Any read waits until the result slot is empty, and a FIFO read also waits for `fifo_pop_valid`. `rd_valid` holds its byte until `rd_ready` is high. `fifo_push_valid` and `fifo_pop_ready` never depend on the ready/valid they are paired with.

Top module: `hif_host_port`

## Requirements
- R1: After reset `host_ready`=1, `rd_valid`=0, `cmd_valid`=0 and no register or FIFO access occurs. Words accepted before an open pulse are consumed and have no effect.
- R2: A head word with bit 7 set and a listed code gives `cmd_valid` high for one cycle, in the cycle after the word is accepted. `cmd_id` is set as follows: 0x80→0, 0x83→1, 0x84→2, 0x85→3, 0x87→4, 0x8F→5, 0x90→6, 0x91→7, 0x92→8, 0x93→9, 0x94→10.
- R3: A head word with bit 7 set and any other code is consumed without a strobe, and the next word is again a head word.
- R4: A head word with bit 7 clear is an address word: bit 6 = read, bit 5 = continuous, bits 4:0 = address. In single write mode the next word is written, with `reg_wr_en`, `reg_addr` and `reg_wdata` valid in its acceptance cycle. The word after that is a head word.
- R5: In continuous mode, successive data words go to successive addresses, starting at the one in the address word.
- R6: In read mode each data-phase word, whatever its value, performs one read. The byte appears on `rd_data` with `rd_valid` high from the cycle after acceptance, and it is held stable until `rd_ready` is high.
- R7: The FIFO address (`FIFO_ADDR`, default 31) never increments. Writes to it push bytes and reads from it pop bytes, in arrival order.
- R8: An address at or above `NUM_REGS` (default 24) other than the FIFO address is undefined. Writes to it cause no `reg_wr_en`, and reads from it return 0.
- R9: A single-end pulse ends head or single mode and goes to idle, and it is ignored in continuous mode. A burst-end pulse takes continuous mode back to head position, and it is ignored elsewhere.
- R10: An open pulse in any state puts the port in head position and drops any pending address.
- R11: In a cycle that carries a framing pulse, `host_ready`=0. A pending word is taken afterwards, in the new state.
- R12: A data-phase word stalls with no access while its target cannot accept it: a full FIFO for writes, a pending result for reads, an empty FIFO for FIFO reads.
- R13: A random mix of single, continuous and command steps inside one bracket leaves every register and strobe as the steps dictate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fr_open | input | 1 | Open pulse, starts a transaction |
| fr_end_single | input | 1 | End pulse for command or single mode |
| fr_end_burst | input | 1 | End pulse for continuous mode |
| host_valid | input | 1 | Host word valid |
| host_ready | output | 1 | Host word accepted when high with valid |
| host_data | input | 8 | Host word |
| rd_valid | output | 1 | Read result valid |
| rd_ready | input | 1 | Read result taken |
| rd_data | output | 8 | Read result byte |
| reg_wr_en | output | 1 | Register write enable |
| reg_rd_en | output | 1 | Register read enable |
| reg_addr | output | 5 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, same cycle |
| fifo_push_valid | output | 1 | FIFO push valid |
| fifo_push_ready | input | 1 | FIFO has room |
| fifo_push_data | output | 8 | FIFO push byte |
| fifo_pop_valid | input | 1 | FIFO holds a byte |
| fifo_pop_ready | output | 1 | FIFO pop request |
| fifo_pop_data | input | 8 | FIFO head byte |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_id | output | 4 | Decoded command index |

## Verification
A framing pulse and a host word can arrive in the same cycle. The bench provokes this by raising a burst-end pulse together with a valid command word while in continuous mode. It then expects `host_ready` low in that cycle, no write of the word as data, and a command strobe once the word is retaken in head position. A pending read result and the next read word can also collide. With `rd_ready` held low, the bench expects the second word to stall and the first byte to stay unchanged until the result is released.

// File: rtl/hif_pkg.sv
package hif_pkg;
  localparam int WORD_W   = 8;
  localparam int ADDR_W   = 5;
  localparam int CMD_BIT  = 7;
  localparam int RD_BIT   = 6;
  localparam int CONT_BIT = 5;
  localparam int NUM_CMDS = 11;
  localparam int CMD_ID_W = $clog2(NUM_CMDS);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HEAD,
    ST_SGL,
    ST_CONT
  } hif_state_e;

  // index in this table is the strobe identifier
  localparam logic [WORD_W-1:0] CMD_CODES [NUM_CMDS] = '{
    8'h80, 8'h83, 8'h84, 8'h85, 8'h87, 8'h8F,
    8'h90, 8'h91, 8'h92, 8'h93, 8'h94
  };
endpackage

// File: rtl/hif_frame_ctl.sv
module hif_frame_ctl
  import hif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fr_open,
  input  logic       fr_end_single,
  input  logic       fr_end_burst,
  input  logic       word_fire,
  input  logic       word_cmd,
  input  logic       word_cont,
  output hif_state_e state
);
  hif_state_e nxt;

  always_comb begin
    nxt = state;
    if (fr_open) begin
      nxt = ST_HEAD;
    end else if (fr_end_single && (state == ST_HEAD || state == ST_SGL)) begin
      nxt = ST_IDLE;
    end else if (fr_end_burst && state == ST_CONT) begin
      nxt = ST_HEAD;
    end else if (word_fire) begin
      case (state)
        ST_HEAD: if (!word_cmd) nxt = word_cont ? ST_CONT : ST_SGL;
        ST_SGL:  nxt = ST_HEAD;
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/hif_cmd_dec.sv
module hif_cmd_dec
  import hif_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [WORD_W-1:0]   code,
  output logic                cmd_valid,
  output logic [CMD_ID_W-1:0] cmd_id
);
  logic [NUM_CMDS-1:0] hit;
  logic [CMD_ID_W-1:0] idx;

  for (genvar k = 0; k < NUM_CMDS; k++) begin : g_match
    assign hit[k] = (code == CMD_CODES[k]);
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < NUM_CMDS; k++) begin
      if (hit[k]) idx = CMD_ID_W'(k);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_id    <= '0;
    end else begin
      cmd_valid <= fire && (|hit);
      if (fire && (|hit)) cmd_id <= idx;
    end
  end
endmodule

// File: rtl/hif_access.sv
module hif_access
  import hif_pkg::*;
#(
  parameter int NUM_REGS  = 24,
  parameter int FIFO_ADDR = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hif_state_e        state,
  input  logic              host_valid,
  input  logic              frm_any,
  input  logic              word_fire,
  input  logic              hd_is_cmd,
  input  logic              hd_rd,
  input  logic [ADDR_W-1:0] hd_addr,
  input  logic [WORD_W-1:0] host_data,
  output logic              access_ok,
  output logic              reg_wr_en,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  input  logic [WORD_W-1:0] reg_rdata,
  output logic              fifo_push_valid,
  input  logic              fifo_push_ready,
  output logic [WORD_W-1:0] fifo_push_data,
  input  logic              fifo_pop_valid,
  output logic              fifo_pop_ready,
  input  logic [WORD_W-1:0] fifo_pop_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data
);
  localparam logic [ADDR_W:0]   NREG  = (ADDR_W+1)'(NUM_REGS);
  localparam logic [ADDR_W-1:0] FADDR = ADDR_W'(FIFO_ADDR);

  logic [ADDR_W-1:0] ptr;
  logic              is_rd;
  logic              in_data;
  logic              at_fifo;
  logic              defined;
  logic              data_fire;
  logic              head_fire;

  assign in_data   = (state == ST_SGL) || (state == ST_CONT);
  assign at_fifo   = (ptr == FADDR);
  assign defined   = ({1'b0, ptr} < NREG);
  assign data_fire = word_fire && in_data;
  assign head_fire = word_fire && (state == ST_HEAD) && !hd_is_cmd;

  always_comb begin
    if (!is_rd) access_ok = at_fifo ? fifo_push_ready : 1'b1;
    else        access_ok = !rd_valid && (at_fifo ? fifo_pop_valid : 1'b1);
  end

  assign reg_addr        = ptr;
  assign reg_wdata       = host_data;
  assign reg_wr_en       = data_fire && !is_rd && !at_fifo && defined;
  assign reg_rd_en       = data_fire && is_rd && !at_fifo && defined;
  assign fifo_push_data  = host_data;
  assign fifo_push_valid = host_valid && in_data && !is_rd && at_fifo && !frm_any;
  assign fifo_pop_ready  = host_valid && in_data && is_rd && at_fifo && !frm_any && !rd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      is_rd <= 1'b0;
    end else if (head_fire) begin
      ptr   <= hd_addr;
      is_rd <= hd_rd;
    end else if (data_fire && state == ST_CONT && !at_fifo) begin
      ptr   <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (data_fire && is_rd) begin
      rd_valid <= 1'b1;
      rd_data  <= at_fifo ? fifo_pop_data : (defined ? reg_rdata : '0);
    end else if (rd_valid && rd_ready) begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hif_host_port.sv
module hif_host_port
  import hif_pkg::*;
#(
  parameter int NUM_REGS  = 24,
  parameter int FIFO_ADDR = 31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fr_open,
  input  logic                fr_end_single,
  input  logic                fr_end_burst,
  input  logic                host_valid,
  output logic                host_ready,
  input  logic [WORD_W-1:0]   host_data,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [WORD_W-1:0]   rd_data,
  output logic                reg_wr_en,
  output logic                reg_rd_en,
  output logic [ADDR_W-1:0]   reg_addr,
  output logic [WORD_W-1:0]   reg_wdata,
  input  logic [WORD_W-1:0]   reg_rdata,
  output logic                fifo_push_valid,
  input  logic                fifo_push_ready,
  output logic [WORD_W-1:0]   fifo_push_data,
  input  logic                fifo_pop_valid,
  output logic                fifo_pop_ready,
  input  logic [WORD_W-1:0]   fifo_pop_data,
  output logic                cmd_valid,
  output logic [CMD_ID_W-1:0] cmd_id
);
  hif_state_e state;
  logic       frm_any;
  logic       access_ok;
  logic       word_fire;
  logic       cmd_fire;

  assign frm_any    = fr_open || fr_end_single || fr_end_burst;
  assign host_ready = !frm_any &&
                      ((state == ST_IDLE) || (state == ST_HEAD) || access_ok);
  assign word_fire  = host_valid && host_ready;
  assign cmd_fire   = word_fire && (state == ST_HEAD) && host_data[CMD_BIT];

  hif_frame_ctl u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .fr_open      (fr_open),
    .fr_end_single(fr_end_single),
    .fr_end_burst (fr_end_burst),
    .word_fire    (word_fire),
    .word_cmd     (host_data[CMD_BIT]),
    .word_cont    (host_data[CONT_BIT]),
    .state        (state)
  );

  hif_cmd_dec u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (cmd_fire),
    .code     (host_data),
    .cmd_valid(cmd_valid),
    .cmd_id   (cmd_id)
  );

  hif_access #(
    .NUM_REGS (NUM_REGS),
    .FIFO_ADDR(FIFO_ADDR)
  ) u_access (
    .clk            (clk),
    .rst_n          (rst_n),
    .state          (state),
    .host_valid     (host_valid),
    .frm_any        (frm_any),
    .word_fire      (word_fire),
    .hd_is_cmd      (host_data[CMD_BIT]),
    .hd_rd          (host_data[RD_BIT]),
    .hd_addr        (host_data[ADDR_W-1:0]),
    .host_data      (host_data),
    .access_ok      (access_ok),
    .reg_wr_en      (reg_wr_en),
    .reg_rd_en      (reg_rd_en),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .fifo_push_valid(fifo_push_valid),
    .fifo_push_ready(fifo_push_ready),
    .fifo_push_data (fifo_push_data),
    .fifo_pop_valid (fifo_pop_valid),
    .fifo_pop_ready (fifo_pop_ready),
    .fifo_pop_data  (fifo_pop_data),
    .rd_valid       (rd_valid),
    .rd_ready       (rd_ready),
    .rd_data        (rd_data)
  );
endmodule

// File: rtl/hif_host_port_chk.sv
module hif_host_port_chk #(
  parameter int NUM_REGS = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       fr_open,
  input logic       fr_end_single,
  input logic       fr_end_burst,
  input logic       host_valid,
  input logic       host_ready,
  input logic [7:0] host_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       reg_wr_en,
  input logic       reg_rd_en,
  input logic [4:0] reg_addr,
  input logic       fifo_push_valid,
  input logic       fifo_push_ready,
  input logic       fifo_pop_valid,
  input logic       fifo_pop_ready,
  input logic       cmd_valid
);
  assert_cmd_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(host_valid && host_ready && host_data[7]));

  assert_frame_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_open || fr_end_single || fr_end_burst) |-> !host_ready);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_undef_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (32'(reg_addr) < NUM_REGS));

  assert_one_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr_en, reg_rd_en, fifo_push_valid && fifo_push_ready,
              fifo_pop_valid && fifo_pop_ready}));

  assert_push_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push_valid && !fifo_push_ready) |-> !host_ready);

  assert_access_needs_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en || reg_rd_en) |-> (host_valid && host_ready));
endmodule

bind hif_host_port hif_host_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (.*);

// File: tb/tb_hif_host_port.sv
`timescale 1ns/1ps
module tb_hif_host_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fr_open = 1'b0, fr_end_single = 1'b0, fr_end_burst = 1'b0;
  logic       host_valid = 1'b0;
  logic       host_ready;
  logic [7:0] host_data = 8'h00;
  logic       rd_valid;
  logic       rd_ready = 1'b1;
  logic [7:0] rd_data;
  logic       reg_wr_en, reg_rd_en;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       fifo_push_valid, fifo_push_ready, fifo_pop_valid, fifo_pop_ready;
  logic [7:0] fifo_push_data, fifo_pop_data;
  logic       cmd_valid;
  logic [3:0] cmd_id;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hif_host_port dut (.*);

  // register file model: asynchronous read, synchronous write
  logic [7:0] mem [32];
  logic [7:0] exp_mem [32];
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (reg_wr_en) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  // FIFO model, 24 entries
  logic [7:0] fbuf [24];
  int fhead = 0, ftail = 0, fcnt = 0;
  assign fifo_push_ready = (fcnt < 24);
  assign fifo_pop_valid  = (fcnt > 0);
  assign fifo_pop_data   = fbuf[fhead];
  always @(posedge clk) begin
    if (!rst_n) begin
      fhead <= 0; ftail <= 0; fcnt <= 0;
    end else begin
      if (fifo_push_valid && fifo_push_ready) begin
        fbuf[ftail] <= fifo_push_data;
        ftail <= (ftail + 1) % 24;
      end
      if (fifo_pop_valid && fifo_pop_ready) fhead <= (fhead + 1) % 24;
      fcnt <= fcnt + int'(fifo_push_valid && fifo_push_ready)
                   - int'(fifo_pop_valid && fifo_pop_ready);
    end
  end

  logic [3:0] got_cmd [$];
  logic [3:0] exp_cmd [$];
  always @(negedge clk) if (rst_n && cmd_valid) got_cmd.push_back(cmd_id);

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic bit cmd_lookup(input logic [7:0] c, output logic [3:0] id);
    cmd_lookup = 1'b1;
    case (c)
      8'h80: id = 4'd0;  8'h83: id = 4'd1;  8'h84: id = 4'd2;
      8'h85: id = 4'd3;  8'h87: id = 4'd4;  8'h8F: id = 4'd5;
      8'h90: id = 4'd6;  8'h91: id = 4'd7;  8'h92: id = 4'd8;
      8'h93: id = 4'd9;  8'h94: id = 4'd10;
      default: begin id = 4'd0; cmd_lookup = 1'b0; end
    endcase
  endfunction

  task automatic send_word(input logic [7:0] w);
    @(posedge clk); #1;
    host_valid = 1'b1; host_data = w;
    forever begin
      @(negedge clk);
      if (host_ready) break;
    end
    @(posedge clk); #1;
    host_valid = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(posedge clk); #1;
    if (which == 0) fr_open = 1'b1;
    else if (which == 1) fr_end_single = 1'b1;
    else fr_end_burst = 1'b1;
    @(posedge clk); #1;
    fr_open = 1'b0; fr_end_single = 1'b0; fr_end_burst = 1'b0;
  endtask

  task automatic read_one(input logic [7:0] expv, input string req);
    send_word(8'h00);
    @(negedge clk);
    check(rd_valid && rd_data == expv, req, rd_data, expv);
  endtask

  task automatic check_mem(input string req);
    for (int i = 0; i < 32; i++)
      check(mem[i] == exp_mem[i], req, mem[i], exp_mem[i]);
  endtask

  task automatic check_cmds(input string req);
    repeat (3) @(negedge clk);
    check(got_cmd.size() == exp_cmd.size(), req, got_cmd.size(), exp_cmd.size());
    for (int i = 0; i < exp_cmd.size() && i < got_cmd.size(); i++)
      check(got_cmd[i] == exp_cmd[i], req, got_cmd[i], exp_cmd[i]);
    got_cmd.delete();
    exp_cmd.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] id;
    logic [7:0] codes [15];
    for (int i = 0; i < 32; i++) exp_mem[i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(host_ready == 1'b1, "R1 ready", host_ready, 1);
    check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    check(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
    check(!reg_wr_en && !fifo_push_valid, "R1 access", reg_wr_en, 0);

    // R1 words outside a transaction
    send_word(8'h05); send_word(8'h55); send_word(8'h83);
    check_mem("R1 idle words");
    check_cmds("R1 idle cmd");

    // R2 and R3 command words, unknown codes interleaved
    codes = '{8'h80, 8'h81, 8'h83, 8'h84, 8'hC0, 8'h85, 8'h87, 8'h95,
              8'h8F, 8'h90, 8'h91, 8'hFF, 8'h92, 8'h93, 8'h94};
    pulse(0);
    foreach (codes[i]) begin
      send_word(codes[i]);
      if (cmd_lookup(codes[i], id)) exp_cmd.push_back(id);
    end
    pulse(1);
    check_cmds("R2 R3 command strobes");

    // R4 single write, R6 single read
    pulse(0);
    send_word(8'h07); send_word(8'hA5); exp_mem[7] = 8'hA5;
    send_word(8'h47); read_one(8'hA5, "R4 R6 single write readback");
    pulse(1);
    check_mem("R4 regfile");

    // R5 continuous write across the defined limit, R8 undefined
    pulse(0);
    send_word(8'h36);
    send_word(8'hB1); send_word(8'hB2); send_word(8'hB3); send_word(8'hB4);
    exp_mem[22] = 8'hB1; exp_mem[23] = 8'hB2;
    pulse(2);
    send_word(8'h76);
    read_one(8'hB1, "R5 burst read 22");
    read_one(8'hB2, "R5 burst read 23");
    read_one(8'h00, "R8 undefined read 24");
    read_one(8'h00, "R8 undefined read 25");
    pulse(2); pulse(1);
    check_mem("R5 R8 regfile");

    // R9 stop rules
    pulse(0);
    send_word(8'h2A); send_word(8'h11);
    pulse(1);                       // ignored in continuous mode
    send_word(8'h22);
    pulse(2);
    pulse(2);                       // ignored in head position
    send_word(8'h0C); send_word(8'h33);
    pulse(1);
    send_word(8'h0D); send_word(8'h44);   // idle again: no effect
    exp_mem[10] = 8'h11; exp_mem[11] = 8'h22; exp_mem[12] = 8'h33;
    check_mem("R9 stop rules");

    // R10 reopen drops a pending address
    pulse(0);
    send_word(8'h05);
    pulse(0);
    send_word(8'h85); exp_cmd.push_back(4'd3);
    pulse(1);
    check_mem("R10 reopen");
    check_cmds("R10 reopen cmd");

    // R11 framing pulse and word in the same cycle
    pulse(0);
    send_word(8'h22); send_word(8'h5A); exp_mem[2] = 8'h5A;
    @(posedge clk); #1;
    host_valid = 1'b1; host_data = 8'h84; fr_end_burst = 1'b1;
    @(negedge clk);
    check(host_ready == 1'b0, "R11 ready during pulse", host_ready, 0);
    @(posedge clk); #1;
    fr_end_burst = 1'b0;
    forever begin
      @(negedge clk);
      if (host_ready) break;
    end
    @(posedge clk); #1;
    host_valid = 1'b0;
    exp_cmd.push_back(4'd2);
    pulse(1);
    check_mem("R11 word not written");
    check_cmds("R11 word as command");

    // R6 R12 read back-pressure
    rd_ready = 1'b0;
    pulse(0);
    send_word(8'h43); send_word(8'h00);
    send_word(8'h64);
    @(posedge clk); #1;
    host_valid = 1'b1; host_data = 8'h00;
    repeat (3) begin
      @(negedge clk);
      check(host_ready == 1'b0, "R12 read stall", host_ready, 0);
      check(rd_valid && rd_data == exp_mem[3], "R6 held result", rd_data, exp_mem[3]);
    end
    @(posedge clk); #1;
    rd_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(host_ready == 1'b1, "R12 read released", host_ready, 1);
    @(posedge clk); #1;
    host_valid = 1'b0;
    @(negedge clk);
    check(rd_valid && rd_data == exp_mem[4], "R6 next burst read", rd_data, exp_mem[4]);
    pulse(2); pulse(1);

    // R7 R12 FIFO fill, stall when full, drain in order
    pulse(0);
    send_word(8'h3F);
    for (int i = 0; i < 24; i++) send_word(8'(i * 5 + 1));
    @(posedge clk); #1;
    host_valid = 1'b1; host_data = 8'hEE;
    repeat (3) begin
      @(negedge clk);
      check(host_ready == 1'b0, "R12 full FIFO stall", host_ready, 0);
    end
    @(posedge clk); #1;
    host_valid = 1'b0;
    pulse(2);
    check(fcnt == 24, "R7 FIFO count", fcnt, 24);
    send_word(8'h7F);
    for (int i = 0; i < 24; i++) read_one(8'(i * 5 + 1), "R7 FIFO order");
    pulse(2); pulse(1);
    check(fcnt == 0, "R7 FIFO drained", fcnt, 0);
    check_mem("R7 regfile untouched");

    // R13 random mixed stream in one bracket
    void'($urandom(32'h5EED));
    pulse(0);
    for (int n = 0; n < 250; n++) begin
      int kind;
      kind = $urandom_range(0, 3);
      if (kind == 0) begin
        int a; logic [7:0] d;
        a = $urandom_range(0, 23); d = 8'($urandom);
        send_word(8'(a)); send_word(d); exp_mem[a] = d;
      end else if (kind == 1) begin
        int a, len;
        a = $urandom_range(0, 20); len = $urandom_range(1, 3);
        send_word(8'h20 | 8'(a));
        for (int k = 0; k < len; k++) begin
          logic [7:0] d;
          d = 8'($urandom);
          send_word(d); exp_mem[a + k] = d;
        end
        pulse(2);
      end else if (kind == 2) begin
        int a;
        a = $urandom_range(0, 30);
        send_word(8'h40 | 8'(a));
        read_one(a < 24 ? exp_mem[a] : 8'h00, "R13 random read");
      end else begin
        logic [7:0] c;
        c = 8'h80 | 8'($urandom_range(0, 31));
        send_word(c);
        if (cmd_lookup(c, id)) exp_cmd.push_back(id);
      end
    end
    pulse(1);
    check_mem("R13 final regfile");
    check_cmds("R13 command strobes");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule